// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a network controller that shares a small memory with a host. The host builds a ring of receive descriptors in that memory. Each descriptor points at a buffer, gives its capacity and carries an ownership bit. The block walks the ring in order. It fetches the descriptor at the current index ahead of time, and it accepts the next incoming frame only if the descriptor is marked as controller-owned. The frame is a byte stream with a last-byte marker and a CRC-error indication. The block writes the bytes into the buffer and writes back the stored length and a status byte. Clearing the ownership bit in that status byte returns the descriptor to the host. The block then raises a receive pulse and moves to the next index.

The host reaches the memory through its own port with a one-cycle read latency, so it can build and recycle descriptors while frames are flowing. If the current descriptor belongs to the host, or has not been fetched yet, an arriving frame is dropped whole and a missed-frame pulse is raised. The index stays where it is, and the block polls that same descriptor until the host hands it over again. The ring base and a ring-length word are quasi-static configuration inputs.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `rx_int` and `miss_int` are low and the ring index is 0, so the first accepted frame lands in descriptor 0.
- R2: Descriptor i occupies four 16-bit words starting at `ring_base + 4*i`. Word 0 holds the low buffer byte address. Word 1 holds the status byte in bits 7:0 and the high address byte in bits 15:8. Word 2 holds the buffer length and word 3 the message length. Status bits are: 0 end-of-frame, 1 start-of-frame, 2 buffer error, 3 CRC error, 4 overflow, 5 framing error, 6 error summary, 7 owned-by-controller.
- R3: Byte n of a frame is written at byte address `{high,low} + n`. A byte at an even address goes to bits 7:0 of the word and a byte at an odd address goes to bits 15:8. No other byte of the word changes.
- R4: A good frame that fits its buffer is written back with status 0x03 (start and end set, owner bit clear), with the high address byte kept. Word 3 is written with the byte count, including the 4 FCS bytes, in bits 11:0 and zero in bits 15:12. The length is written before the status.
- R5: The buffer capacity is the low 12 bits of the two's-complement negation of word 2 (the host stores `-N` with bits 15:12 set). For a longer frame only the first N bytes are stored, the status is 0x52 (start, overflow, error) and the length is N.
- R6: A frame whose last byte carries `rx_crc_err` is written back with status 0x4B (end, start, CRC, error).
- R7: `rx_int` is a one-cycle pulse for each written-back descriptor. It appears in the cycle after the status write, so the descriptor is complete once the pulse is seen.
- R8: The ring holds 2^k descriptors, where k is `ring_cfg[15:13]`. The index advances modulo that size, so after the last descriptor the next frame uses descriptor 0.
- R9: A frame that starts while the current descriptor is host-owned or still being fetched, including a frame that starts during a write-back, is dropped with no memory write. `miss_int` pulses once for that frame.
- R10: While the current descriptor is host-owned the index does not move. Once the host sets the owner bit of that same descriptor, the next frame is stored there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host memory access enable |
| host_we | input | 2 | Host byte-lane write enables (bit 0 = bits 7:0) |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the access |
| ring_base | input | ADDR_W | Word address of descriptor 0 |
| ring_cfg | input | 16 | Ring-length word; bits 15:13 hold log2 of the ring size |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_crc_err | input | 1 | CRC error, sampled with the last byte |
| rx_int | output | 1 | One-cycle pulse per written-back descriptor |
| miss_int | output | 1 | One-cycle pulse per dropped frame |

## Verification
The status write-back of one frame and the drop decision for the next can fall in the same cycle. If a new frame begins exactly as the status word is written, `rx_int` and `miss_int` rise together. The bench sends two frames with a single idle cycle between them, so the second frame starts on the write-back cycle of the first. It then expects exactly one cycle in which both pulses are high. It also checks that the first descriptor is complete and that the second frame left memory untouched.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // status byte bit positions
  localparam int FLG_ENP  = 0;
  localparam int FLG_STP  = 1;
  localparam int FLG_BUFF = 2;
  localparam int FLG_CRC  = 3;
  localparam int FLG_OFLO = 4;
  localparam int FLG_FRAM = 5;
  localparam int FLG_ERR  = 6;
  localparam int FLG_OWN  = 7;

  // word offsets inside one descriptor
  localparam int DW_LO   = 0;
  localparam int DW_FLAG = 1;
  localparam int DW_BLEN = 2;
  localparam int DW_MLEN = 3;

  // bit position of the ring size code in the ring-length word
  localparam int RING_CODE_LSB = 13;
  localparam int RING_CODE_W   = 3;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_CHECK,
    ST_LOAD_LO,
    ST_LOAD_LEN,
    ST_READY,
    ST_RECV,
    ST_WB_LEN,
    ST_WB_FLAG
  } rxr_state_e;
endpackage

// File: rtl/rxr_dpram.sv
module rxr_dpram #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 2
) (
  input  logic                  clk,
  input  logic                  a_en,
  input  logic [LANES-1:0]      a_we,
  input  logic [ADDR_W-1:0]     a_addr,
  input  logic [LANES*8-1:0]    a_wdata,
  output logic [LANES*8-1:0]    a_rdata,
  input  logic                  b_en,
  input  logic [LANES-1:0]      b_we,
  input  logic [ADDR_W-1:0]     b_addr,
  input  logic [LANES*8-1:0]    b_wdata,
  output logic [LANES*8-1:0]    b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = LANES * 8;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // read-first on both ports; port B wins a same-address write collision
  always_ff @(posedge clk) begin
    if (a_en) begin
      a_rdata <= mem[a_addr];
      for (int l = 0; l < LANES; l++)
        if (a_we[l]) mem[a_addr][l*8 +: 8] <= a_wdata[l*8 +: 8];
    end
    if (b_en) begin
      b_rdata <= mem[b_addr];
      for (int l = 0; l < LANES; l++)
        if (b_we[l]) mem[b_addr][l*8 +: 8] <= b_wdata[l*8 +: 8];
    end
  end
endmodule

// File: rtl/rxr_ring_index.sv
module rxr_ring_index
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [15:0]       ring_cfg,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] desc_addr
);
  logic [RING_CODE_W-1:0] size_code;
  logic [IDX_W-1:0]       mask;
  logic [RING_CODE_LSB-1:0] unused_cfg_bits;

  assign size_code       = ring_cfg[RING_CODE_LSB +: RING_CODE_W];
  assign unused_cfg_bits = ring_cfg[RING_CODE_LSB-1:0];
  assign mask            = ~({IDX_W{1'b1}} << size_code);
  assign desc_addr       = ring_base + ADDR_W'({idx, 2'b00});

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (advance) idx <= (idx + 1'b1) & mask;
  end

  // R8: the index never leaves the configured ring
  a_r8_idx_within_ring: assert property (@(posedge clk) disable iff (rst)
    (idx & ~mask) == '0);
endmodule

// File: rtl/rxr_frame_track.sv
module rxr_frame_track (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic rx_last,
  output logic sof
);
  logic in_frame;

  assign sof = rx_valid && !in_frame;

  always_ff @(posedge clk) begin
    if (rst)           in_frame <= 1'b0;
    else if (rx_valid) in_frame <= !rx_last;
  end
endmodule

// File: rtl/rxr_desc_engine.sv
module rxr_desc_engine
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_crc_err,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [15:0]       b_rdata,
  output logic              b_en,
  output logic [1:0]        b_we,
  output logic [ADDR_W-1:0] b_addr,
  output logic [15:0]       b_wdata,
  output logic              advance,
  output logic              rx_int,
  output logic              miss_int
);
  localparam int CNT_W = 12;

  rxr_state_e       state;
  logic [15:0]      buf_lo;
  logic [7:0]       buf_hi;
  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             crc;

  logic             accept;
  logic             store;
  logic [15:0]      byte_addr;
  logic [15:0]      neg_len;
  logic [7:0]       status;
  logic [15-ADDR_W-1:0] unused_addr_bits;

  assign accept    = (state == ST_READY && sof) || (state == ST_RECV && rx_valid);
  assign store     = accept && (cnt < cap);
  assign byte_addr = buf_lo + {4'h0, cnt};
  assign neg_len   = ~b_rdata + 16'd1;
  assign unused_addr_bits = byte_addr[15:ADDR_W+1];

  always_comb begin
    status           = 8'h00;
    status[FLG_STP]  = 1'b1;
    status[FLG_ENP]  = !ovf;
    status[FLG_CRC]  = crc && !ovf;
    status[FLG_OFLO] = ovf;
    status[FLG_ERR]  = ovf || crc;
  end

  // controller memory port, one user per cycle
  always_comb begin
    b_en    = 1'b0;
    b_we    = 2'b00;
    b_addr  = desc_addr;
    b_wdata = 16'h0000;
    advance = 1'b0;
    case (state)
      ST_FETCH: begin
        b_en   = 1'b1;
        b_addr = desc_addr + ADDR_W'(DW_FLAG);
      end
      ST_CHECK: begin
        if (b_rdata[FLG_OWN]) begin
          b_en   = 1'b1;
          b_addr = desc_addr + ADDR_W'(DW_LO);
        end
      end
      ST_LOAD_LO: begin
        b_en   = 1'b1;
        b_addr = desc_addr + ADDR_W'(DW_BLEN);
      end
      ST_WB_LEN: begin
        b_en    = 1'b1;
        b_we    = 2'b11;
        b_addr  = desc_addr + ADDR_W'(DW_MLEN);
        b_wdata = {4'h0, cnt};
      end
      ST_WB_FLAG: begin
        b_en    = 1'b1;
        b_we    = 2'b11;
        b_addr  = desc_addr + ADDR_W'(DW_FLAG);
        b_wdata = {buf_hi, status};
        advance = 1'b1;
      end
      default: begin
        if (store) begin
          b_en    = 1'b1;
          b_we    = byte_addr[0] ? 2'b10 : 2'b01;
          b_addr  = byte_addr[ADDR_W:1];
          b_wdata = {rx_data, rx_data};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FETCH;
      buf_lo   <= '0;
      buf_hi   <= '0;
      cap      <= '0;
      cnt      <= '0;
      ovf      <= 1'b0;
      crc      <= 1'b0;
      rx_int   <= 1'b0;
      miss_int <= 1'b0;
    end else begin
      rx_int   <= 1'b0;
      miss_int <= sof && (state != ST_READY);
      case (state)
        ST_FETCH: state <= ST_CHECK;
        ST_CHECK: begin
          if (b_rdata[FLG_OWN]) begin
            buf_hi <= b_rdata[15:8];
            state  <= ST_LOAD_LO;
          end else begin
            state  <= ST_FETCH;
          end
        end
        ST_LOAD_LO: begin
          buf_lo <= b_rdata;
          state  <= ST_LOAD_LEN;
        end
        ST_LOAD_LEN: begin
          cap   <= neg_len[CNT_W-1:0];
          cnt   <= '0;
          ovf   <= 1'b0;
          crc   <= 1'b0;
          state <= ST_READY;
        end
        ST_READY, ST_RECV: begin
          if (accept) begin
            if (store) cnt <= cnt + 1'b1;
            else       ovf <= 1'b1;
            if (rx_last) begin
              crc   <= rx_crc_err;
              state <= ST_WB_LEN;
            end else begin
              state <= ST_RECV;
            end
          end
        end
        ST_WB_LEN: state <= ST_WB_FLAG;
        default: begin
          rx_int <= 1'b1;
          state  <= ST_FETCH;
        end
      endcase
    end
  end

  // R7: status write-back is followed by one receive pulse
  a_r7_int_after_status: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB_FLAG) |=> rx_int);
  a_r7_int_single_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_int |=> !rx_int);
  // R4: the length word is written in the cycle before the status word
  a_r4_len_before_status: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB_FLAG) |-> $past(state == ST_WB_LEN));
  // R9: a miss pulse needs a frame start without a ready descriptor
  a_r9_miss_cause: assert property (@(posedge clk) disable iff (rst)
    miss_int |-> $past(sof && state != ST_READY));
  // R10: a host-owned descriptor keeps the index in place
  a_r10_hold_on_host_owned: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHECK && !b_rdata[FLG_OWN]) |=> $stable(idx));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_en,
  input  logic [1:0]        host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [15:0]       ring_cfg,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_crc_err,
  output logic              rx_int,
  output logic              miss_int
);
  localparam int IDX_W = (1 << rxr_pkg::RING_CODE_W) - 1;

  logic              sof;
  logic              advance;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] desc_addr;
  logic              b_en;
  logic [1:0]        b_we;
  logic [ADDR_W-1:0] b_addr;
  logic [15:0]       b_wdata;
  logic [15:0]       b_rdata;

  rxr_dpram #(.ADDR_W(ADDR_W), .LANES(2)) u_mem (
    .clk     (clk),
    .a_en    (host_en),
    .a_we    (host_we),
    .a_addr  (host_addr),
    .a_wdata (host_wdata),
    .a_rdata (host_rdata),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_rdata (b_rdata)
  );

  rxr_ring_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .ring_base (ring_base),
    .ring_cfg  (ring_cfg),
    .idx       (idx),
    .desc_addr (desc_addr)
  );

  rxr_frame_track u_track (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_last  (rx_last),
    .sof      (sof)
  );

  rxr_desc_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .sof        (sof),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_last    (rx_last),
    .rx_crc_err (rx_crc_err),
    .desc_addr  (desc_addr),
    .idx        (idx),
    .b_rdata    (b_rdata),
    .b_en       (b_en),
    .b_we       (b_we),
    .b_addr     (b_addr),
    .b_wdata    (b_wdata),
    .advance    (advance),
    .rx_int     (rx_int),
    .miss_int   (miss_int)
  );
endmodule

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
  localparam int ADDR_W = 9;

  logic              clk = 1'b0;
  logic              rst;
  logic              host_en;
  logic [1:0]        host_we;
  logic [ADDR_W-1:0] host_addr;
  logic [15:0]       host_wdata;
  logic [15:0]       host_rdata;
  logic [ADDR_W-1:0] ring_base;
  logic [15:0]       ring_cfg;
  logic              rx_valid;
  logic [7:0]        rx_data;
  logic              rx_last;
  logic              rx_crc_err;
  logic              rx_int;
  logic              miss_int;

  always #2 clk = ~clk;

  rx_ring_writer #(.ADDR_W(ADDR_W)) i_rx_ring_writer (
    .clk(clk), .rst(rst),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ring_base(ring_base), .ring_cfg(ring_cfg),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_crc_err(rx_crc_err), .rx_int(rx_int), .miss_int(miss_int)
  );

  int checks = 0;
  int errors = 0;
  int rx_pulses = 0;
  int miss_pulses = 0;
  int both_pulses = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_int) rx_pulses++;
      if (miss_int) miss_pulses++;
      if (rx_int && miss_int) both_pulses++;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input logic [7:0] seed, input int i);
    return seed + 8'(i * 3);
  endfunction

  task automatic host_wr(input int addr, input logic [15:0] data);
    @(negedge clk);
    host_en = 1'b1; host_we = 2'b11; host_addr = ADDR_W'(addr); host_wdata = data;
    @(negedge clk);
    host_en = 1'b0; host_we = 2'b00;
  endtask

  task automatic host_rd(input int addr, output logic [15:0] data);
    @(negedge clk);
    host_en = 1'b1; host_we = 2'b00; host_addr = ADDR_W'(addr);
    @(negedge clk);
    host_en = 1'b0;
    data = host_rdata;
  endtask

  task automatic send_frame(input logic [7:0] seed, input int len, input bit crc_bad);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb(seed, i);
      rx_last = (i == len - 1); rx_crc_err = (i == len - 1) && crc_bad;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_buffer(input string req, input int wbase, input logic [7:0] seed, input int len);
    logic [15:0] d;
    for (int k = 0; 2 * k < len; k++) begin
      host_rd(wbase + k, d);
      if (2 * k + 1 < len) check(req, d, {fb(seed, 2 * k + 1), fb(seed, 2 * k)});
      else                 check(req, {8'h00, d[7:0]}, {8'h00, fb(seed, 2 * k)});
    end
  endtask

  // descriptor i: buffer at byte 0x100 + 0x40*i, capacity 32 (0xFFE0), high byte 0x5A
  task automatic setup_desc(input int i, input bit own);
    host_wr(4 * i + 0, 16'(16'h0100 + i * 16'h0040));
    host_wr(4 * i + 2, 16'hFFE0);
    host_wr(4 * i + 3, 16'h0000);
    host_wr(4 * i + 1, own ? 16'h5A80 : 16'h5A00);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    idle(5);
    check("R1 rx_int low in reset", {15'h0, rx_int}, 16'h0);
    check("R1 miss_int low in reset", {15'h0, miss_int}, 16'h0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    check("R1 rx_int low after reset", {15'h0, rx_int}, 16'h0);
    check("R1 miss_int low after reset", {15'h0, miss_int}, 16'h0);
  endtask

  task automatic t_good_frame;
    int r0, m0;
    logic [15:0] d;
    r0 = rx_pulses; m0 = miss_pulses;
    send_frame(8'h10, 10, 1'b0);
    idle(25);
    check("R7 one rx pulse cycle per frame", 16'(rx_pulses - r0), 16'd1);
    check("R9 no miss for owned descriptor", 16'(miss_pulses - m0), 16'd0);
    host_rd(1, d); check("R1 R4 status of descriptor 0", d, 16'h5A03);
    host_rd(3, d); check("R4 message length", d, 16'h000A);
    check_buffer("R3 R2 frame bytes in buffer 0", 16'h80, 8'h10, 10);
  endtask

  task automatic t_crc_frame;
    logic [15:0] d;
    send_frame(8'h40, 7, 1'b1);
    idle(25);
    host_rd(5, d); check("R6 CRC status", d, 16'h5A4B);
    host_rd(7, d); check("R6 CRC length", d, 16'h0007);
    check_buffer("R3 odd frame bytes", 16'hA0, 8'h40, 7);
    host_rd(16'hA3, d); check("R3 untouched upper lane", d, {8'hEE, fb(8'h40, 6)});
  endtask

  task automatic t_missed_frame;
    int r0, m0;
    logic [15:0] d;
    r0 = rx_pulses; m0 = miss_pulses;
    send_frame(8'h70, 9, 1'b0);
    idle(25);
    check("R9 miss pulse count", 16'(miss_pulses - m0), 16'd1);
    check("R9 no rx pulse", 16'(rx_pulses - r0), 16'd0);
    host_rd(9, d); check("R9 host-owned status kept", d, 16'h5A00);
    host_rd(16'hC0, d); check("R9 buffer not written", d, 16'hA5A5);
  endtask

  task automatic t_resume_overflow;
    logic [15:0] d;
    host_wr(9, 16'h5A80);
    idle(25);
    send_frame(8'h90, 40, 1'b0);
    idle(25);
    host_rd(9, d); check("R10 R5 released descriptor used, overflow status", d, 16'h5A52);
    host_rd(11, d); check("R5 overflow length", d, 16'h0020);
    check_buffer("R5 first 32 bytes stored", 16'hC0, 8'h90, 32);
    host_rd(16'hD0, d); check("R5 nothing past capacity", d, 16'hA5A5);
    host_rd(13, d); check("R10 next descriptor untouched", d, 16'h5A00);
  endtask

  task automatic t_wrap;
    logic [15:0] d;
    host_wr(3, 16'h0000);
    host_wr(1, 16'h5A80);
    host_wr(13, 16'h5A80);
    idle(25);
    send_frame(8'hB0, 4, 1'b0);
    idle(25);
    host_rd(13, d); check("R8 last descriptor status", d, 16'h5A03);
    host_rd(15, d); check("R8 last descriptor length", d, 16'h0004);
    send_frame(8'hC0, 12, 1'b0);
    idle(25);
    host_rd(1, d); check("R8 wrapped to descriptor 0", d, 16'h5A03);
    host_rd(3, d); check("R8 wrapped length", d, 16'h000C);
    check_buffer("R8 wrapped bytes", 16'h80, 8'hC0, 12);
  endtask

  task automatic t_back_to_back;
    int r0, m0, b0;
    logic [15:0] d;
    host_wr(7, 16'h0000);
    host_wr(5, 16'h5A80);
    idle(25);
    r0 = rx_pulses; m0 = miss_pulses; b0 = both_pulses;
    send_frame(8'hD0, 6, 1'b0);
    send_frame(8'hE0, 6, 1'b0);
    idle(25);
    check("R7 rx pulse for first frame", 16'(rx_pulses - r0), 16'd1);
    check("R9 miss pulse for frame during write-back", 16'(miss_pulses - m0), 16'd1);
    check("R7 R9 both pulses in one cycle", 16'(both_pulses - b0), 16'd1);
    host_rd(5, d); check("R4 first frame status", d, 16'h5A03);
    host_rd(7, d); check("R4 first frame length", d, 16'h0006);
    host_rd(9, d); check("R9 next descriptor unchanged", d, 16'h5A52);
    host_rd(16'hC0, d); check("R9 second frame not stored", d, {fb(8'h90, 1), fb(8'h90, 0)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    host_en = 1'b0; host_we = 2'b00; host_addr = '0; host_wdata = '0;
    ring_base = '0; ring_cfg = 16'h4000;   // 4 descriptors
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_crc_err = 1'b0;
    t_reset();
    host_wr(16'hA3, 16'hEEEE);
    host_wr(16'hC0, 16'hA5A5);
    host_wr(16'hD0, 16'hA5A5);
    setup_desc(3, 1'b0);
    setup_desc(2, 1'b0);
    setup_desc(1, 1'b1);
    setup_desc(0, 1'b1);
    idle(25);
    t_good_frame();
    t_crc_frame();
    t_missed_frame();
    t_resume_overflow();
    t_wrap();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule